// File: doc/BRIEF.md
# RTC Status Flags, Interrupt Routing and Charger Key Register

This block keeps the sticky event flags of a serial real-time clock and turns them into two active-low interrupt lines. Three flags live in one status byte: oscillator halted, alarm-1 hit and alarm-0 hit. Each flag is a two-state machine. The states are `FLG_CLR` and `FLG_SET`. The transition `FLG_CLR -> FLG_SET` is taken on a set event. The transition `FLG_SET -> FLG_CLR` is taken on a clearing event, and there are two kinds of clearing event. The first is a bus write that carries a zero in the flag's bit. The second, for the alarm flags only, is a load of the address pointer with a value inside that alarm's register window. A set event and a clearing event in the same cycle leave the flag in `FLG_SET`.

The same block holds the trickle-charge control byte. A second two-state machine guards the charger: `CHG_LOCK` (charger off) and `CHG_ARM` (charger on). Every write to the byte re-evaluates the guard. A write whose upper nibble equals the key takes `CHG_LOCK -> CHG_ARM` or stays in `CHG_ARM`. Any other write takes `CHG_ARM -> CHG_LOCK` or stays in `CHG_LOCK`. The diode and resistor selections reach the analog section only in `CHG_ARM`.

The bus front end, the timekeeping counters and the alarm comparators sit outside this block. They deliver single-cycle hit pulses, the oscillator run level, the pointer-load strobe and the interrupt control bits.

Top module: `rtc_stat_irq`

## Requirements
- R1: After reset, the status byte at address 0x10 reads 0x80 (oscillator flag set, both alarm flags clear). The charge byte at 0x11 reads 0x00, chg_en is 0, and irq0_n and irq1_n are both 1.
- R2: A one-cycle pulse on alm0_hit sets status bit 0, and a pulse on alm1_hit sets status bit 1. The flag is visible on bus_rdata after the next rising edge and remains set after the pulse ends.
- R3: A 1-to-0 change of osc_running sets status bit 7 one edge later. A 0-to-1 change leaves bit 7 unchanged.
- R4: A bus write to 0x10 clears each flag whose write-data bit (7, 1 or 0) is 0 and leaves unchanged each flag whose bit is 1. Status bits 6..2 always read 0.
- R5: A ptr_load with ptr_val in 0x0B..0x0E clears the alarm-1 flag. A ptr_load with ptr_val in 0x07..0x0A clears the alarm-0 flag. A pointer value outside both windows clears nothing, and the oscillator flag is never cleared by a pointer load.
- R6: When a hit pulse and a clearing event for the same flag fall in the same cycle, the flag ends up set.
- R7: irq0_n is 0 exactly when (alarm-0 flag and a0_ie) or (alarm-1 flag and a1_ie and route_sel = 0).
- R8: irq1_n is 0 exactly when the alarm-1 flag, a1_ie and route_sel are all 1.
- R9: The byte written to 0x11 reads back unchanged. chg_en is 1 only while bits 7:4 of that byte equal 4'b1010.
- R10: While chg_en is 1, chg_diode shows bits 3:2 and chg_res shows bits 1:0 of the charge byte. Otherwise both are 2'b00.
- R11: bus_rdata reads 0x00 for any address other than 0x10 and 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ptr_load | input | 1 | Address pointer loaded this cycle |
| ptr_val | input | 8 | New pointer value |
| osc_running | input | 1 | Oscillator run level |
| alm0_hit | input | 1 | Alarm-0 match pulse |
| alm1_hit | input | 1 | Alarm-1 match pulse |
| route_sel | input | 1 | Steers alarm 1 to irq1_n when 1, to irq0_n when 0 |
| a0_ie | input | 1 | Alarm-0 interrupt enable |
| a1_ie | input | 1 | Alarm-1 interrupt enable |
| irq0_n | output | 1 | Interrupt line 0, active low |
| irq1_n | output | 1 | Interrupt line 1, active low |
| chg_en | output | 1 | Charger enabled |
| chg_diode | output | 2 | Diode selection to the analog section |
| chg_res | output | 2 | Resistor selection to the analog section |

## Verification
If a flag machine sits in the wrong state, the status byte shows it on the next read. When the matching enable is on, the interrupt line also shows it in the same cycle, because both are driven combinationally from the flag registers. The failures that need a specific setup are a clear that beats a simultaneous set and a pointer-window boundary off by one. The first only shows when the two events share a cycle. The second only shows at the edge values of the window, so the bench drives both ends of each window and the addresses just outside them. If the charger guard is wrong, chg_en and the selection outputs show it one edge after the byte is written.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;

    typedef enum logic {
        FLG_CLR = 1'b0,
        FLG_SET = 1'b1
    } flag_st_t;

    typedef enum logic {
        CHG_LOCK = 1'b0,
        CHG_ARM  = 1'b1
    } chg_st_t;

    localparam int NUM_FLAGS = 3;
    localparam int IDX_A0    = 0;
    localparam int IDX_A1    = 1;
    localparam int IDX_OSC   = 2;

    function automatic logic in_window(input logic [7:0] v,
                                       input logic [7:0] lo,
                                       input logic [7:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell
    import rtc_stat_pkg::*;
#(
    parameter logic RST_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_SET ? FLG_SET : FLG_CLR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLR: if (set_i) st_d = FLG_SET;
            FLG_SET: if (!set_i && clr_i) st_d = FLG_CLR;
            default: st_d = FLG_CLR;
        endcase
    end

    always_comb begin
        flag_o = (st_q == FLG_SET);
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (st_q == FLG_SET));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && clr_i) |=> (st_q == FLG_CLR));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(st_q));

endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route (
    input  logic clk,
    input  logic rst_n,
    input  logic a0_flag,
    input  logic a1_flag,
    input  logic a0_ie,
    input  logic a1_ie,
    input  logic route_sel,
    output logic irq0_n,
    output logic irq1_n
);

    logic a0_req, a1_req;

    always_comb begin
        a0_req = a0_flag & a0_ie;
        a1_req = a1_flag & a1_ie;
        irq0_n = ~(a0_req | (a1_req & ~route_sel));
        irq1_n = ~(a1_req & route_sel);
    end

    // R8
    irq1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq1_n |-> (route_sel && a1_flag));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a0_ie && !a1_ie) |-> (irq0_n && irq1_n));

endmodule

// File: rtl/rtc_charge_reg.sv
module rtc_charge_reg
    import rtc_stat_pkg::*;
#(
    parameter logic [3:0] KEY = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       chg_en_o,
    output logic [1:0] diode_o,
    output logic [1:0] res_o
);

    chg_st_t    st_q, st_d;
    logic [3:0] tcs_q;
    logic [1:0] ds_q, rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CHG_LOCK;
            tcs_q <= '0;
            ds_q  <= '0;
            rs_q  <= '0;
        end else begin
            st_q <= st_d;
            if (wr_i) begin
                tcs_q <= wdata_i[7:4];
                ds_q  <= wdata_i[3:2];
                rs_q  <= wdata_i[1:0];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CHG_LOCK: if (wr_i && wdata_i[7:4] == KEY) st_d = CHG_ARM;
            CHG_ARM:  if (wr_i && wdata_i[7:4] != KEY) st_d = CHG_LOCK;
            default:  st_d = CHG_LOCK;
        endcase
    end

    always_comb begin
        rdata_o  = {tcs_q, ds_q, rs_q};
        chg_en_o = (st_q == CHG_ARM);
        diode_o  = chg_en_o ? ds_q : 2'b00;
        res_o    = chg_en_o ? rs_q : 2'b00;
    end

    // R9
    key_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en_o |-> (tcs_q == KEY));

    // R10
    no_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en_o |-> (diode_o == 2'b00 && res_o == 2'b00));

endmodule

// File: rtl/rtc_stat_irq.sv
module rtc_stat_irq
    import rtc_stat_pkg::*;
#(
    parameter logic [7:0] STAT_ADDR = 8'h10,
    parameter logic [7:0] CHG_ADDR  = 8'h11,
    parameter logic [7:0] A0_LO     = 8'h07,
    parameter logic [7:0] A0_HI     = 8'h0A,
    parameter logic [7:0] A1_LO     = 8'h0B,
    parameter logic [7:0] A1_HI     = 8'h0E,
    parameter logic [3:0] CHG_KEY   = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ptr_load,
    input  logic [7:0] ptr_val,
    input  logic       osc_running,
    input  logic       alm0_hit,
    input  logic       alm1_hit,
    input  logic       route_sel,
    input  logic       a0_ie,
    input  logic       a1_ie,
    output logic       irq0_n,
    output logic       irq1_n,
    output logic       chg_en,
    output logic [1:0] chg_diode,
    output logic [1:0] chg_res
);

    localparam int BIT_A0  = 0;
    localparam int BIT_A1  = 1;
    localparam int BIT_OSC = 7;
    localparam logic [NUM_FLAGS-1:0] RST_VEC = 3'b100;

    logic                 osc_q;
    logic                 stat_wr, chg_wr;
    logic [NUM_FLAGS-1:0] set_v, clr_v, flag_v;
    logic [NUM_FLAGS-1:0] wr_zero_v, auto_v;
    logic [7:0]           stat_byte, chg_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_q <= 1'b0;
        else        osc_q <= osc_running;
    end

    always_comb begin
        stat_wr = bus_wr && (bus_addr == STAT_ADDR);
        chg_wr  = bus_wr && (bus_addr == CHG_ADDR);

        set_v[IDX_A0]  = alm0_hit;
        set_v[IDX_A1]  = alm1_hit;
        set_v[IDX_OSC] = osc_q & ~osc_running;

        wr_zero_v[IDX_A0]  = stat_wr && !bus_wdata[BIT_A0];
        wr_zero_v[IDX_A1]  = stat_wr && !bus_wdata[BIT_A1];
        wr_zero_v[IDX_OSC] = stat_wr && !bus_wdata[BIT_OSC];

        auto_v[IDX_A0]  = ptr_load && in_window(ptr_val, A0_LO, A0_HI);
        auto_v[IDX_A1]  = ptr_load && in_window(ptr_val, A1_LO, A1_HI);
        auto_v[IDX_OSC] = 1'b0;

        clr_v = wr_zero_v | auto_v;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        rtc_flag_cell #(.RST_SET(RST_VEC[g])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .flag_o (flag_v[g])
        );
    end

    rtc_irq_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .a0_flag   (flag_v[IDX_A0]),
        .a1_flag   (flag_v[IDX_A1]),
        .a0_ie     (a0_ie),
        .a1_ie     (a1_ie),
        .route_sel (route_sel),
        .irq0_n    (irq0_n),
        .irq1_n    (irq1_n)
    );

    rtc_charge_reg #(.KEY(CHG_KEY)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (chg_wr),
        .wdata_i  (bus_wdata),
        .rdata_o  (chg_byte),
        .chg_en_o (chg_en),
        .diode_o  (chg_diode),
        .res_o    (chg_res)
    );

    always_comb begin
        stat_byte          = '0;
        stat_byte[BIT_OSC] = flag_v[IDX_OSC];
        stat_byte[BIT_A1]  = flag_v[IDX_A1];
        stat_byte[BIT_A0]  = flag_v[IDX_A0];
        if (bus_addr == STAT_ADDR)     bus_rdata = stat_byte;
        else if (bus_addr == CHG_ADDR) bus_rdata = chg_byte;
        else                           bus_rdata = 8'h00;
    end

    // R3
    osc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_q && !osc_running) |=> flag_v[IDX_OSC]);

    // R5
    osc_no_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v[IDX_OSC] && !stat_wr) |=> flag_v[IDX_OSC]);

endmodule

// File: tb/sim_rtc_stat_irq.sv
module sim_rtc_stat_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ptr_load = 1'b0;
    logic [7:0] ptr_val = 8'h00;
    logic       osc_running = 1'b1;
    logic       alm0_hit = 1'b0;
    logic       alm1_hit = 1'b0;
    logic       route_sel = 1'b0;
    logic       a0_ie = 1'b0;
    logic       a1_ie = 1'b0;
    logic       irq0_n, irq1_n, chg_en;
    logic [1:0] chg_diode, chg_res;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_stat_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .osc_running(osc_running), .alm0_hit(alm0_hit),
        .alm1_hit(alm1_hit), .route_sel(route_sel), .a0_ie(a0_ie), .a1_ie(a1_ie),
        .irq0_n(irq0_n), .irq1_n(irq1_n), .chg_en(chg_en),
        .chg_diode(chg_diode), .chg_res(chg_res)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_hits(input logic h0, input logic h1);
        @(negedge clk);
        alm0_hit = h0; alm1_hit = h1;
        @(negedge clk);
        alm0_hit = 1'b0; alm1_hit = 1'b0;
    endtask

    task automatic load_ptr(input logic [7:0] v);
        @(negedge clk);
        ptr_load = 1'b1; ptr_val = v;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        read_at(8'h10, d); check("R1 status", d, 8'h80);
        read_at(8'h11, d); check("R1 charge", d, 8'h00);
        check("R1 chg_en", {7'd0, chg_en}, 8'h00);
        check("R1 irqs", {6'd0, irq1_n, irq0_n}, 8'h03);
    endtask

    task automatic t_alarm_set;
        logic [7:0] d;
        bus_write(8'h10, 8'h00);
        pulse_hits(1'b1, 1'b0);
        read_at(8'h10, d); check("R2 a0 set", d, 8'h01);
        repeat (3) @(negedge clk);
        read_at(8'h10, d); check("R2 a0 sticky", d, 8'h01);
        pulse_hits(1'b0, 1'b1);
        read_at(8'h10, d); check("R2 a1 set", d, 8'h03);
    endtask

    task automatic t_osc;
        logic [7:0] d;
        bus_write(8'h10, 8'h00);
        @(negedge clk); osc_running = 1'b0;
        @(negedge clk);
        read_at(8'h10, d); check("R3 fall sets", d, 8'h80);
        bus_write(8'h10, 8'h00);
        @(negedge clk); osc_running = 1'b1;
        repeat (2) @(negedge clk);
        read_at(8'h10, d); check("R3 rise no effect", d, 8'h00);
    endtask

    task automatic t_write_clear;
        logic [7:0] d;
        bus_write(8'h10, 8'h00);
        pulse_hits(1'b1, 1'b1);
        bus_write(8'h10, 8'hFF);
        read_at(8'h10, d); check("R4 write ones keep", d, 8'h03);
        bus_write(8'h10, 8'hFD);
        read_at(8'h10, d); check("R4 clear a1 only", d, 8'h01);
        bus_write(8'h10, 8'hFE);
        read_at(8'h10, d); check("R4 clear a0", d, 8'h00);
    endtask

    task automatic t_ptr_clear;
        logic [7:0] d;
        bus_write(8'h10, 8'h00);
        @(negedge clk); osc_running = 1'b0;
        @(negedge clk); osc_running = 1'b1;
        pulse_hits(1'b1, 1'b1);
        read_at(8'h10, d); check("R5 setup", d, 8'h83);
        load_ptr(8'h06);
        load_ptr(8'h0F);
        read_at(8'h10, d); check("R5 outside windows", d, 8'h83);
        load_ptr(8'h0B);
        read_at(8'h10, d); check("R5 a1 low edge", d, 8'h81);
        load_ptr(8'h0A);
        read_at(8'h10, d); check("R5 a0 high edge", d, 8'h80);
        pulse_hits(1'b1, 1'b1);
        load_ptr(8'h0E);
        load_ptr(8'h07);
        read_at(8'h10, d); check("R5 other edges, osc kept", d, 8'h80);
    endtask

    task automatic t_set_wins;
        logic [7:0] d;
        bus_write(8'h10, 8'h00);
        @(negedge clk);
        alm1_hit = 1'b1; ptr_load = 1'b1; ptr_val = 8'h0C;
        @(negedge clk);
        alm1_hit = 1'b0; ptr_load = 1'b0;
        read_at(8'h10, d); check("R6 set beats pointer", d, 8'h02);
        @(negedge clk);
        alm0_hit = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 8'h00;
        @(negedge clk);
        alm0_hit = 1'b0; bus_wr = 1'b0;
        read_at(8'h10, d); check("R6 set beats write", d, 8'h01);
    endtask

    task automatic t_irq_route;
        bus_write(8'h10, 8'h00);
        pulse_hits(1'b0, 1'b1);
        a1_ie = 1'b1; route_sel = 1'b0;
        #1 check("R7 a1 on line 0", {6'd0, irq1_n, irq0_n}, 8'h02);
        route_sel = 1'b1;
        #1 check("R8 a1 on line 1", {6'd0, irq1_n, irq0_n}, 8'h01);
        a1_ie = 1'b0;
        #1 check("R8 a1 disabled", {6'd0, irq1_n, irq0_n}, 8'h03);
        pulse_hits(1'b1, 1'b0);
        a0_ie = 1'b1;
        #1 check("R7 a0 on line 0", {6'd0, irq1_n, irq0_n}, 8'h02);
        a0_ie = 1'b0; route_sel = 1'b0;
        #1 check("R7 none enabled", {6'd0, irq1_n, irq0_n}, 8'h03);
    endtask

    task automatic t_charger;
        logic [7:0] d;
        bus_write(8'h11, 8'hA6);
        read_at(8'h11, d); check("R9 readback", d, 8'hA6);
        check("R9 enabled", {7'd0, chg_en}, 8'h01);
        check("R10 selects", {4'd0, chg_diode, chg_res}, 8'h06);
        bus_write(8'h11, 8'hB7);
        read_at(8'h11, d); check("R9 readback off", d, 8'hB7);
        check("R9 wrong key", {7'd0, chg_en}, 8'h00);
        check("R10 no path", {4'd0, chg_diode, chg_res}, 8'h00);
        bus_write(8'h11, 8'h2F);
        check("R9 near key", {7'd0, chg_en}, 8'h00);
        bus_write(8'h11, 8'hAB);
        check("R10 selects again", {4'd0, chg_diode, chg_res}, 8'h0B);
    endtask

    task automatic t_other_addr;
        logic [7:0] d;
        pulse_hits(1'b1, 1'b1);
        read_at(8'h12, d); check("R11 addr 12", d, 8'h00);
        read_at(8'h0F, d); check("R11 addr 0F", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alarm_set();
        t_osc();
        t_write_clear();
        t_ptr_clear();
        t_set_wins();
        t_irq_route();
        t_charger();
        t_other_addr();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule